// File: doc/BRIEF.md
# All-Ones Alarm Signal Detector

This block watches a received serial bit stream, one bit per qualifying strobe, and raises an alarm status when the stream has become almost entirely ones. Alarm is raised whenever the most recent 2048 received bits hold fewer than three zeros. It drops again as soon as the latest 2048 bits hold three zeros or more. The window slides one bit at a time, so the decision is refreshed with every received bit and is not tied to fixed blocks.

Each change of the alarm status, in either direction, sets a sticky change flag. The flag stays set until a host clear pulse removes it. An interrupt request follows the flag unless a mask input blocks it. Internally the detector keeps only the ages, in bits, of the three newest zeros, so no 2048-bit history store is needed.

Top module: `aisDetector`

## Requirements
- R1: After reset, aisActive, aisFlag and irqReq are all 0.
- R2: After the clock edge that samples a valid bit, aisActive is 1 when fewer than three zeros lie among that bit and the 2047 valid bits before it. Bits received before reset count as ones, so a stream with fewer than three zeros since reset raises the alarm.
- R3: After the clock edge that samples a valid bit, aisActive is 0 when that bit and the 2047 valid bits before it contain three or more zeros.
- R4: A zero exactly 2047 valid bits older than the current bit still counts as inside the window. One bit later it no longer counts.
- R5: While bitValid is 0, aisActive and the zero tracking are unchanged, whatever bitIn carries.
- R6: Any valid bit that changes aisActive sets aisFlag at the same clock edge.
- R7: aisFlag stays 1 until a cycle with flagClear = 1 and no status change. When a status change and flagClear fall in the same cycle, aisFlag is 1 afterwards.
- R8: irqReq is 1 exactly when aisFlag is 1 and irqMask is 0. It follows irqMask within the same cycle.
- R9: An all-ones run of any length, including one far longer than 4096 bits, keeps aisActive at 1. After such a run the alarm clears on the third zero received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Qualifies bitIn for this cycle |
| bitIn | input | 1 | Received data bit |
| irqMask | input | 1 | 1 blocks the interrupt request |
| flagClear | input | 1 | 1 clears the change flag |
| aisActive | output | 1 | Alarm status |
| aisFlag | output | 1 | Sticky status-change flag |
| irqReq | output | 1 | Interrupt request |

## Verification
A bit sampled at one rising edge updates aisActive and aisFlag at that same edge, so both results belong to the edge that follows the negative edge where the driver presented the bit. irqReq is combinational from the flag and the mask, so it reflects the mask being driven at that moment. The driver queues one expected record per cycle, built from a plain 2048-bit history model and a flag model. The monitor pops each record half a high phase after the rising edge, which is the first point where all three outputs are settled. The window edge is exercised on every bit of a run longer than 2048 ones, and it is checked against each zero's exact age.

// File: rtl/aisPkg.sv
package aisPkg;
  typedef struct packed {
    logic advance;  // a valid bit is consumed this cycle
    logic zeroIn;   // the consumed bit is a zero
  } aisStrobeT;
endpackage

// File: rtl/aisAgeDp.sv
module aisAgeDp
  import aisPkg::*;
#(
  parameter int WINDOW     = 2048,
  parameter int ZERO_LIMIT = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  aisStrobeT strobe,
  output logic      spanShortNext
);
  localparam int AGE_W = $clog2(WINDOW + 1);
  localparam logic [AGE_W-1:0] SAT = AGE_W'(WINDOW);

  logic [AGE_W-1:0] ageQ [ZERO_LIMIT];
  logic [AGE_W-1:0] ageD [ZERO_LIMIT];

  function automatic logic [AGE_W-1:0] bumpAge(input logic [AGE_W-1:0] a);
    return (a >= SAT) ? SAT : a + 1'b1;
  endfunction

  for (genvar i = 0; i < ZERO_LIMIT; i++) begin : g_age
    if (i == 0) begin : g_newest
      always_comb ageD[i] = strobe.zeroIn ? '0 : bumpAge(ageQ[i]);
    end else begin : g_older
      always_comb ageD[i] = strobe.zeroIn ? bumpAge(ageQ[i-1]) : bumpAge(ageQ[i]);
    end

    always_ff @(posedge clk) begin
      if (!rstN)               ageQ[i] <= SAT;
      else if (strobe.advance) ageQ[i] <= ageD[i];
    end

    p_age_bounded_r9: assert property (@(posedge clk) disable iff (!rstN)
      ageQ[i] <= SAT);
    p_age_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.advance |=> $stable(ageQ[i]));
  end

  // oldest tracked zero out of the window after this bit
  assign spanShortNext = (ageD[ZERO_LIMIT-1] >= SAT);

  p_zero_restarts_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.zeroIn) |=> ageQ[0] == '0);
endmodule

// File: rtl/aisCtrl.sv
module aisCtrl
  import aisPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitValid,
  input  logic      bitIn,
  input  logic      flagClear,
  input  logic      spanShortNext,
  output aisStrobeT strobe,
  output logic      aisActive,
  output logic      aisFlag
);
  logic statusChange;

  always_comb begin
    strobe.advance = bitValid;
    strobe.zeroIn  = bitValid && !bitIn;
  end

  assign statusChange = strobe.advance && (spanShortNext != aisActive);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aisActive <= 1'b0;
      aisFlag   <= 1'b0;
    end else begin
      if (strobe.advance) aisActive <= spanShortNext;
      if (statusChange)   aisFlag   <= 1'b1;
      else if (flagClear) aisFlag   <= 1'b0;
    end
  end

  p_ais_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> $stable(aisActive));
  p_flag_on_change_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(aisActive) |-> aisFlag);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (aisFlag && !flagClear) |=> aisFlag);
endmodule

// File: rtl/aisDetector.sv
module aisDetector #(
  parameter int WINDOW     = 2048,
  parameter int ZERO_LIMIT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitValid,
  input  logic bitIn,
  input  logic irqMask,
  input  logic flagClear,
  output logic aisActive,
  output logic aisFlag,
  output logic irqReq
);
  aisPkg::aisStrobeT strobe;
  logic spanShortNext;

  aisCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .flagClear(flagClear), .spanShortNext(spanShortNext),
    .strobe(strobe), .aisActive(aisActive), .aisFlag(aisFlag)
  );

  aisAgeDp #(.WINDOW(WINDOW), .ZERO_LIMIT(ZERO_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .spanShortNext(spanShortNext)
  );

  assign irqReq = aisFlag && !irqMask;

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> aisFlag);
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqMask |-> !irqReq);
endmodule

// File: tb/aisDetector_bench.sv
module aisDetector_bench;
  localparam int WIN = 2048;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0, bitIn = 1'b1, irqMask = 1'b0, flagClear = 1'b0;
  logic aisActive, aisFlag, irqReq;

  int checks = 0;
  int errors = 0;
  logic driverDone = 1'b0;

  typedef struct {
    logic  ais;
    logic  flag;
    logic  irq;
    string tag;
  } expT;
  expT sbQ[$];

  // reference model: raw history, newest bit in [0]
  logic [WIN-1:0] hist = '1;
  int   zeroCnt = 0;
  logic mAis = 1'b0;
  logic mFlag = 1'b0;

  always #10 clk = ~clk;

  aisDetector u_aisDetector (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .irqMask(irqMask), .flagClear(flagClear),
    .aisActive(aisActive), .aisFlag(aisFlag), .irqReq(irqReq)
  );

  task automatic step(input logic v, input logic b, input logic m,
                      input logic c, input string tag);
    logic newAis;
    logic changed;
    expT e;
    @(negedge clk);
    bitValid = v; bitIn = b; irqMask = m; flagClear = c;
    newAis = mAis;
    if (v) begin
      if (hist[WIN-1] == 1'b0) zeroCnt--;
      hist = {hist[WIN-2:0], b};
      if (b == 1'b0) zeroCnt++;
      newAis = (zeroCnt < 3);
    end
    changed = (newAis != mAis);
    mAis = newAis;
    if (changed)  mFlag = 1'b1;
    else if (c)   mFlag = 1'b0;
    e.ais = mAis; e.flag = mFlag; e.irq = mFlag && !m; e.tag = tag;
    sbQ.push_back(e);
  endtask

  task automatic ones(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, 1'b0, tag);
  endtask

  // monitor: results due at the edge after the drive, sampled mid high phase
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbQ.size() > 0) begin
        expT e;
        e = sbQ.pop_front();
        checks++;
        if (aisActive !== e.ais || aisFlag !== e.flag || irqReq !== e.irq) begin
          errors++;
          $display("FAIL %s: ais/flag/irq got %b%b%b expected %b%b%b",
                   e.tag, aisActive, aisFlag, irqReq, e.ais, e.flag, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    checks++;  // R1 reset state
    if (aisActive !== 1'b0 || aisFlag !== 1'b0 || irqReq !== 1'b0) begin
      errors++;
      $display("FAIL R1: ais/flag/irq got %b%b%b expected 000", aisActive, aisFlag, irqReq);
    end
    ones(5, "R2 raise on sparse zeros");            // also R6 flag set
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R8 masked irq");
    step(1'b0, 1'b1, 1'b0, 1'b1, "R7 clear flag");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R3 first zero");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R3 second zero");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R3 third zero clears");
    step(1'b0, 1'b1, 1'b0, 1'b1, "R7 clear");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R5 invalid zeros ignored");
    ones(WIN + 20, "R4 window edge");              // alarm returns at exact age
    step(1'b0, 1'b1, 1'b0, 1'b1, "R7 clear");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R5 invalid while alarm");
    step(1'b1, 1'b0, 1'b0, 1'b1, "R7 clear with zero");
    step(1'b1, 1'b0, 1'b0, 1'b1, "R7 clear with zero");
    step(1'b1, 1'b0, 1'b0, 1'b1, "R7 change beats clear");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R7 flag sticky");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R8 mask follows");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R8 unmask");
    ones(5000, "R9 long ones run");
    step(1'b0, 1'b1, 1'b0, 1'b1, "R7 clear");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R9 zero after run");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R9 zero after run");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R9 third zero clears");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R9 idle");
    @(negedge clk); @(negedge clk);
    driverDone = 1'b1;
  end

  initial begin
    fork
      wait (driverDone && sbQ.size() == 0);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule